// File: doc/BRIEF.md
# Cascadable Segment Column Data Loader

This block collects one row of display data for a 240-column segment driver. The data arrives on a parallel bus that is 8 bits wide, or 4 bits wide with two transfers joined into each internal byte. A strobe marks each transfer, and a row pulse ends the row. Several loaders can share one bus. A chip-enable chain runs through them, so each loader takes its share of the row in turn. When a loader has counted its full row, it stops and hands the enable to the next loader in the chain.

The falling edge of the row pulse copies the collected row, all at once, into a line register. For every column, the block then produces a 2-bit drive-level code. The code depends on the column's bit in the line register, the frame-inversion input and an active-low display-enable input. The strobe and the row pulse are asynchronous to the system clock. They are synchronised through two flops and edge-detected. A falling edge at a pin acts on the third rising system clock edge after it.

Top module: `seg_row_loader`

## Requirements
- R1: After the asynchronous active-low reset, the line register holds zeros and the loader waits for selection. Both enable outputs are high. With frame_inv low, every column shows code 2'b10.
- R2: The bus is sampled on the falling edge of xck_in, and the row is copied into the line register on the falling edge of lp_in. Each falling edge acts on the third rising clock edge after the pin falls. Between row-pulse falls, drive_codes does not follow newly loaded data.
- R3: With nibble_mode=0 and lr_dir=0, the row fills from column 239 downward, one byte per strobe fall. The first byte puts di[7] at column 239 and di[0] at column 232.
- R4: With lr_dir=1, the row fills from column 0 upward with the bit order mirrored. The first 8-bit byte puts di[7] at column 0 and di[0] at column 7.
- R5: With nibble_mode=1, only di[3:0] is used and two strobe falls make one byte. With lr_dir=0, the first nibble puts di[3] at column 239 and di[0] at column 236, and the second nibble fills columns 235 down to 232.
- R6: After each row-pulse fall, the loader waits. It takes data from the first strobe fall at which its enable input is low. The enable input is chain_b_in when lr_dir=0 and chain_a_in when lr_dir=1. While it is not selected, strobes leave the stored row unchanged.
- R7: After exactly 240 bits, the loader stops. Further strobe falls before the next row-pulse fall change nothing.
- R8: The enable output is chain_a_out when lr_dir=0 and chain_b_out when lr_dir=1, and the other output stays high. The enable output goes low at the strobe fall that takes the 240th bit. It stays low for exactly one strobe period, until the next strobe fall.
- R9: With blank_n high, each column's code follows from frame_inv and its line bit: {frame_inv, bit} = 00 gives 2'b10 (V43), 01 gives 2'b11 (V5), 10 gives 2'b01 (V12) and 11 gives 2'b00 (V0). Column c occupies drive_codes[2c+1:2c].
- R10: While blank_n is low, every code is 2'b11 and the line register is held at zero, but row loading continues. After release, the codes show the non-select level for the current frame_inv until the next row-pulse fall shows the loaded row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xck_in | input | 1 | Data strobe, asynchronous, acts on its falling edge |
| lp_in | input | 1 | Row pulse, asynchronous, acts on its falling edge |
| di | input | 8 | Parallel display data |
| nibble_mode | input | 1 | 1: 4-bit bus on di[3:0]; 0: 8-bit bus |
| lr_dir | input | 1 | Fill direction and enable-chain direction |
| frame_inv | input | 1 | Frame inversion for the drive waveform |
| blank_n | input | 1 | Active-low display enable; low forces V5 |
| chain_a_in | input | 1 | Enable input on side A (used when lr_dir=1) |
| chain_b_in | input | 1 | Enable input on side B (used when lr_dir=0) |
| chain_a_out | output | 1 | Enable output on side A (used when lr_dir=0) |
| chain_b_out | output | 1 | Enable output on side B (used when lr_dir=1) |
| drive_codes | output | 480 | Two-bit drive level per column, column c at [2c+1:2c] |

## Verification
A wrong word counter shows up at the chain output. The low pulse then comes early, comes late or never ends, and this is visible at the strobe fall where the count goes wrong. A wrong slot index, a wrong bit order or a stray write stays hidden in the row store. It appears in drive_codes three clock edges after the next row-pulse fall, so the bench compares the full code vector against a behavioural model on every clock. A missed clear of the line register under blank_n shows as a wrong non-select level as soon as blank_n is released.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ld_state_e;

    localparam logic [1:0] LVL_V0  = 2'b00;
    localparam logic [1:0] LVL_V12 = 2'b01;
    localparam logic [1:0] LVL_V43 = 2'b10;
    localparam logic [1:0] LVL_V5  = 2'b11;

endpackage

// File: rtl/fall_sync.sv
module fall_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    localparam int HIST_W = SYNC_STAGES + 1;

    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = {hist_q[HIST_W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign fall_o = hist_q[SYNC_STAGES] & ~hist_q[SYNC_STAGES-1];

endmodule

// File: rtl/row_ctrl.sv
module row_ctrl
    import seg_loader_pkg::*;
#(
    parameter int NUM_COLS = 240,
    parameter int WORD_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xck_fall,
    input  logic                          lp_fall,
    input  logic                          en_in_n,
    input  logic                          nibble_mode,
    input  logic                          lr_dir,
    input  logic [WORD_W-1:0]             di,
    output logic                          wr_en,
    output logic [$clog2(NUM_COLS/WORD_W)-1:0] wr_slot,
    output logic [WORD_W-1:0]             wr_word,
    output logic                          eo_low
);
    localparam int NUM_WORDS = NUM_COLS / WORD_W;
    localparam int CNT_W     = $clog2(NUM_WORDS);
    localparam int HALF      = WORD_W / 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

    typedef struct packed {
        ld_state_e        st;
        logic [CNT_W-1:0] wcnt;
        logic             half;
        logic [HALF-1:0]  nib;
        logic             eo_low;
    } ctrl_t;

    ctrl_t d, q;
    logic [WORD_W-1:0] raw;
    logic              take;

    always_comb begin
        d     = q;
        wr_en = 1'b0;
        raw   = di;
        take  = 1'b0;
        if (lp_fall) begin
            d.st     = ST_WAIT;
            d.wcnt   = '0;
            d.half   = 1'b0;
            d.eo_low = 1'b0;
        end else if (xck_fall) begin
            take = (q.st == ST_RUN) || (q.st == ST_WAIT && !en_in_n);
            if (q.st == ST_DONE) d.eo_low = 1'b0;
            if (take) begin
                d.st = ST_RUN;
                if (nibble_mode && !q.half) begin
                    d.nib  = di[HALF-1:0];
                    d.half = 1'b1;
                end else begin
                    wr_en  = 1'b1;
                    raw    = nibble_mode ? {q.nib, di[HALF-1:0]} : di;
                    d.half = 1'b0;
                    if (q.wcnt == LAST) begin
                        d.st     = ST_DONE;
                        d.eo_low = 1'b1;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
        end
        for (int b = 0; b < WORD_W; b++) begin
            wr_word[b] = lr_dir ? raw[WORD_W-1-b] : raw[b];
        end
        wr_slot = lr_dir ? q.wcnt : LAST - q.wcnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_WAIT;
            q.wcnt   <= '0;
            q.half   <= 1'b0;
            q.nib    <= '0;
            q.eo_low <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign eo_low = q.eo_low;

    // R6: a row pulse rearms the loader
    p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lp_fall |=> (q.st == ST_WAIT && q.wcnt == '0 && !q.eo_low));

    // R6: an unselected loader stays waiting
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && xck_fall && en_in_n && !lp_fall) |=> q.st == ST_WAIT);

    // R7: word counter never passes the last slot
    p_wcnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.wcnt <= LAST);

    // R8: the enable pulse only exists once the row is complete
    p_eo_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.eo_low |-> q.st == ST_DONE);

    // R8: the enable pulse ends at the next strobe fall
    p_eo_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.eo_low && xck_fall) |=> !q.eo_low);

endmodule

// File: rtl/level_enc.sv
module level_enc
    import seg_loader_pkg::*;
#(
    parameter int NUM_COLS = 240
) (
    input  logic [NUM_COLS-1:0]   line,
    input  logic                  frame_inv,
    input  logic                  blank_n,
    output logic [2*NUM_COLS-1:0] codes
);
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        always_comb begin
            if (!blank_n) begin
                codes[2*c +: 2] = LVL_V5;
            end else begin
                case ({frame_inv, line[c]})
                    2'b00:   codes[2*c +: 2] = LVL_V43;
                    2'b01:   codes[2*c +: 2] = LVL_V5;
                    2'b10:   codes[2*c +: 2] = LVL_V12;
                    default: codes[2*c +: 2] = LVL_V0;
                endcase
            end
        end
    end

endmodule

// File: rtl/seg_row_loader.sv
module seg_row_loader
    import seg_loader_pkg::*;
#(
    parameter int NUM_COLS    = 240,
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xck_in,
    input  logic                  lp_in,
    input  logic [WORD_W-1:0]     di,
    input  logic                  nibble_mode,
    input  logic                  lr_dir,
    input  logic                  frame_inv,
    input  logic                  blank_n,
    input  logic                  chain_a_in,
    input  logic                  chain_b_in,
    output logic                  chain_a_out,
    output logic                  chain_b_out,
    output logic [2*NUM_COLS-1:0] drive_codes
);
    localparam int SLOT_W = $clog2(NUM_COLS / WORD_W);

    typedef struct packed {
        logic [NUM_COLS-1:0] row;
        logic [NUM_COLS-1:0] line;
    } store_t;

    store_t d, q;
    logic xck_fall, lp_fall, wr_en, eo_low, en_in_n;
    logic [SLOT_W-1:0] wr_slot;
    logic [WORD_W-1:0] wr_word;

    fall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_xck_sync (
        .clk(clk), .rst_n(rst_n), .async_i(xck_in), .fall_o(xck_fall)
    );

    fall_sync #(.SYNC_STAGES(SYNC_STAGES)) u_lp_sync (
        .clk(clk), .rst_n(rst_n), .async_i(lp_in), .fall_o(lp_fall)
    );

    assign en_in_n = lr_dir ? chain_a_in : chain_b_in;

    row_ctrl #(.NUM_COLS(NUM_COLS), .WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .xck_fall(xck_fall), .lp_fall(lp_fall),
        .en_in_n(en_in_n), .nibble_mode(nibble_mode), .lr_dir(lr_dir),
        .di(di), .wr_en(wr_en), .wr_slot(wr_slot), .wr_word(wr_word),
        .eo_low(eo_low)
    );

    always_comb begin
        d = q;
        if (wr_en) d.row[int'(wr_slot)*WORD_W +: WORD_W] = wr_word;
        if (lp_fall) d.line = blank_n ? q.row : '0;
        if (!blank_n) d.line = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign chain_a_out = lr_dir ? 1'b1 : ~eo_low;
    assign chain_b_out = lr_dir ? ~eo_low : 1'b1;

    level_enc #(.NUM_COLS(NUM_COLS)) u_enc (
        .line(q.line), .frame_inv(frame_inv), .blank_n(blank_n),
        .codes(drive_codes)
    );

    // R10: blanking holds the line register cleared
    p_blank_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> q.line == '0);

    // R10: blanking forces V5 on every column
    p_blank_codes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> &drive_codes);

    // R2: the line register only changes on a row pulse
    p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_fall && blank_n) |=> $stable(q.line));

    // R8: the idle chain output stays high
    p_idle_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lr_dir ? chain_a_out : chain_b_out);

endmodule

// File: tb/sim_seg_row_loader.sv
module sim_seg_row_loader;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 240;
    localparam int XH = 3;

    logic clk = 0, rst_n = 0;
    logic xck = 0, lp = 0, md = 0, lr = 0, fr = 0, blank_n = 1;
    logic a_in = 1, b_in = 1;
    logic [7:0] di = 0;
    logic a_out, b_out;
    logic [2*NC-1:0] codes;

    int checks = 0, bad = 0;
    bit finished = 0;
    int a_lo = 0, b_lo = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_row_loader u0 (
        .clk(clk), .rst_n(rst_n), .xck_in(xck), .lp_in(lp), .di(di),
        .nibble_mode(md), .lr_dir(lr), .frame_inv(fr), .blank_n(blank_n),
        .chain_a_in(a_in), .chain_b_in(b_in), .chain_a_out(a_out),
        .chain_b_out(b_out), .drive_codes(codes)
    );

    // behavioural reference model
    logic [NC-1:0] m_row, m_line;
    logic [2:0] m_xh, m_lh;
    int m_n, m_st;
    bit m_eo;

    always @(posedge clk) begin
        bit xf, lf, take;
        int w, col;
        if (!rst_n) begin
            m_row = '0; m_line = '0; m_xh = '0; m_lh = '0;
            m_n = 0; m_st = 0; m_eo = 0;
        end else begin
            xf = m_xh[2] && !m_xh[1];
            lf = m_lh[2] && !m_lh[1];
            m_xh = {m_xh[1:0], xck};
            m_lh = {m_lh[1:0], lp};
            if (lf) begin
                m_line = blank_n ? m_row : '0;
                m_st = 0; m_n = 0; m_eo = 0;
            end else if (xf) begin
                if (m_st == 2) m_eo = 0;
                take = (m_st == 1) || (m_st == 0 && !(lr ? a_in : b_in));
                if (take) begin
                    m_st = 1;
                    w = md ? 4 : 8;
                    for (int k = w - 1; k >= 0; k--) begin
                        col = lr ? m_n : NC - 1 - m_n;
                        m_row[col] = di[k];
                        m_n++;
                    end
                    if (m_n >= NC) begin m_st = 2; m_eo = 1; end
                end
            end
            if (!blank_n) m_line = '0;
        end
    end

    function automatic logic [2*NC-1:0] exp_codes();
        logic [2*NC-1:0] v;
        for (int c = 0; c < NC; c++) begin
            if (!blank_n) v[2*c +: 2] = 2'b11;
            else case ({fr, m_line[c]})
                2'b00: v[2*c +: 2] = 2'b10;
                2'b01: v[2*c +: 2] = 2'b11;
                2'b10: v[2*c +: 2] = 2'b01;
                default: v[2*c +: 2] = 2'b00;
            endcase
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic ea, eb;
            checks++;
            if (codes !== exp_codes()) begin
                bad++;
                $display("FAIL R9 model codes at %0t: got %h exp %h", $time, codes, exp_codes());
            end
            ea = lr ? 1'b1 : ~m_eo;
            eb = lr ? ~m_eo : 1'b1;
            checks++;
            if (a_out !== ea || b_out !== eb) begin
                bad++;
                $display("FAIL R8 model enable: got a=%b b=%b exp a=%b b=%b", a_out, b_out, ea, eb);
            end
            if (!a_out) a_lo++;
            if (!b_out) b_lo++;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    function automatic int col_code(input int c);
        return int'(codes[2*c +: 2]);
    endfunction

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe(input logic [7:0] d);
        di = d; xck = 1; clocks(XH);
        xck = 0; clocks(XH);
    endtask

    task automatic row_pulse();
        lp = 1; clocks(XH);
        lp = 0; clocks(XH + 1);
    endtask

    initial begin
        clocks(3);
        rst_n = 1;
        clocks(2);
        @(negedge clk);
        chk("R1 reset col0", col_code(0), 2);
        chk("R1 reset col239", col_code(239), 2);
        chk("R1 reset a_out", int'(a_out), 1);
        chk("R1 reset b_out", int'(b_out), 1);

        // 8-bit, fill downward, enable on side B
        md = 0; lr = 0; b_in = 0; a_in = 1; a_lo = 0; b_lo = 0;
        for (int w = 0; w < 30; w++)
            strobe(w == 0 ? 8'hA5 : (w == 29 ? 8'h00 : 8'((w * 37) & 255)));
        @(negedge clk);
        chk("R2 no show before row pulse", col_code(239), 2);
        strobe(8'hFF);
        chk("R8 enable low length", a_lo, 2 * XH);
        chk("R8 idle side high", b_lo, 0);
        row_pulse();
        @(negedge clk);
        chk("R3 col239 di7", col_code(239), 3);
        chk("R3 col238 di6", col_code(238), 2);
        chk("R3 col232 di0", col_code(232), 3);
        chk("R7 extra strobe ignored col0", col_code(0), 2);
        fr = 1; #1;
        chk("R9 fr1 data1", col_code(239), 0);
        chk("R9 fr1 data0", col_code(238), 1);
        fr = 0;

        // 8-bit, fill upward, enable on side A
        lr = 1; a_in = 0; b_in = 1; a_lo = 0; b_lo = 0;
        for (int w = 0; w < 30; w++) strobe(w == 0 ? 8'hC1 : 8'(w));
        strobe(8'h00);
        chk("R8 upward enable on B", b_lo, 2 * XH);
        chk("R8 upward A idle", a_lo, 0);
        row_pulse();
        @(negedge clk);
        chk("R4 col0 di7", col_code(0), 3);
        chk("R4 col2 di5", col_code(2), 2);
        chk("R4 col7 di0", col_code(7), 3);

        // 4-bit, fill downward
        md = 1; lr = 0; b_in = 0; a_in = 1;
        for (int n = 0; n < 60; n++) strobe(n == 0 ? 8'hF9 : (n == 1 ? 8'hF6 : 8'hF0));
        row_pulse();
        @(negedge clk);
        chk("R5 col239", col_code(239), 3);
        chk("R5 col238", col_code(238), 2);
        chk("R5 col236", col_code(236), 3);
        chk("R5 col235", col_code(235), 2);
        chk("R5 col234", col_code(234), 3);

        // not selected: row must stay
        md = 0; b_in = 1;
        for (int w = 0; w < 30; w++) strobe(8'h00);
        row_pulse();
        @(negedge clk);
        chk("R6 unselected keeps col239", col_code(239), 3);
        chk("R6 unselected keeps col238", col_code(238), 2);

        // blanking
        blank_n = 0; b_in = 0; #1;
        chk("R10 blank col100", col_code(100), 3);
        chk("R10 blank col239", col_code(239), 3);
        for (int w = 0; w < 30; w++) strobe(w == 0 ? 8'h80 : 8'h00);
        row_pulse();
        blank_n = 1; fr = 1; clocks(1);
        @(negedge clk);
        chk("R10 non-select after release", col_code(239), 1);
        row_pulse();
        @(negedge clk);
        chk("R10 row loaded during blank", col_code(239), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule